// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a 32-bit virtual address onto a 30-bit physical address through a four-entry table of segment descriptors. The two most significant address bits pick a descriptor. The remaining 30 bits form an offset. Each descriptor carries a valid flag, a physical base and an inclusive limit. Software loads descriptors one at a time through a register-write port.

When a request is presented, the block checks the offset against the limit and adds the base to the offset. The physical address is this sum, not a concatenation. One cycle later the block returns either the translated address or a fault. Faults come from three causes: an empty descriptor, an offset past the limit, or a sum that does not fit in 30 bits.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid_o`, `fault_o` and `paddr_o` are all 0, and every descriptor is invalid, so a request issued before any write returns a fault.
- R2: `vaddr_i[31:30]` selects the descriptor and `vaddr_i[29:0]` is the offset.
- R3: For a valid descriptor whose limit is not exceeded and whose sum fits, `paddr_o` equals base plus offset. For example, segment 2 with base 0x2000 and offset 0x200 gives 0x2200.
- R4: An offset strictly greater than the limit gives `fault_o`=1 and `paddr_o`=0. An offset equal to the limit translates normally.
- R5: A request that selects a descriptor whose valid flag is 0 gives `fault_o`=1 and `paddr_o`=0.
- R6: If base plus offset is 2^30 or more, the result is `fault_o`=1 and `paddr_o`=0.
- R7: `rsp_valid_o` is 1 in exactly the cycle after a cycle with `req_i`=1. In any cycle where `rsp_valid_o` is 0, `paddr_o` and `fault_o` are 0. Back-to-back requests each get a response.
- R8: A descriptor write is seen by requests in the following cycle. A request in the same cycle as a write to its descriptor uses the old contents.
- R9: A write with `wr_valid_i`=0 empties the descriptor, so later requests to that segment fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Descriptor write strobe |
| wr_idx_i | input | 2 | Descriptor index to write |
| wr_valid_i | input | 1 | Valid flag to store |
| wr_base_i | input | 30 | Physical base to store |
| wr_limit_i | input | 30 | Inclusive offset limit to store |
| req_i | input | 1 | Translation request |
| vaddr_i | input | 32 | Virtual address |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| paddr_o | output | 30 | Translated physical address (0 on fault) |
| fault_o | output | 1 | Translation fault |

## Verification
The hardest case to reach is a descriptor write and a request that both land on one edge. The bench drives both in the same cycle and expects the old base. It then issues a request in the very next cycle and expects the new base. Overflow past 30 bits needs a descriptor whose base sits near the top of physical space and whose limit is wide open. One such descriptor is installed, so that in-limit offsets either just fit or just wrap. The inclusive limit is probed at the limit itself and one past it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned VA_W_DEF  = 32;
  localparam int unsigned PA_W_DEF  = 30;
  localparam int unsigned SEG_W_DEF = 2;

  typedef enum logic [1:0] {
    XL_OK       = 2'd0,
    XL_NO_ENTRY = 2'd1,
    XL_LIMIT    = 2'd2,
    XL_WRAP     = 2'd3
  } xl_status_e;
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file #(
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned BASE_W = 30,
  parameter int unsigned LIM_W  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic [LIM_W-1:0]  wr_limit_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [BASE_W-1:0] rd_base_o,
  output logic [LIM_W-1:0]  rd_limit_o
);
  localparam int unsigned N_ENT = 1 << IDX_W;

  logic              valid_q [N_ENT];
  logic [BASE_W-1:0] base_q  [N_ENT];
  logic [LIM_W-1:0]  limit_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        base_q[g]  <= '0;
        limit_q[g] <= '0;
      end else if (sel) begin
        valid_q[g] <= wr_valid_i;
        base_q[g]  <= wr_base_i;
        limit_q[g] <= wr_limit_i;
      end
    end
  end

  // read is from stored state: a same-edge write is not visible
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_base_o  = base_q[rd_idx_i];
  assign rd_limit_o = limit_q[rd_idx_i];

  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (valid_q[$past(wr_idx_i)] == $past(wr_valid_i)) &&
                (base_q[$past(wr_idx_i)]  == $past(wr_base_i)) &&
                (limit_q[$past(wr_idx_i)] == $past(wr_limit_i)));

  p_no_write_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(valid_q[0]) && $stable(base_q[0]) && $stable(limit_q[0]));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned BASE_W = 30,
  parameter int unsigned LIM_W  = 30
) (
  input  logic              ent_valid_i,
  input  logic [BASE_W-1:0] ent_base_i,
  input  logic [LIM_W-1:0]  ent_limit_i,
  input  logic [LIM_W-1:0]  offset_i,
  output xl_status_e        status_o,
  output logic [BASE_W-1:0] sum_o
);
  localparam int unsigned SUM_W = ((BASE_W > LIM_W) ? BASE_W : LIM_W) + 1;

  logic [SUM_W-1:0] sum_full;
  logic             wrap;

  assign sum_full = SUM_W'(ent_base_i) + SUM_W'(offset_i);
  assign wrap     = |sum_full[SUM_W-1:BASE_W];
  assign sum_o    = sum_full[BASE_W-1:0];

  // priority: empty entry, then limit, then wrap
  always_comb begin
    if (!ent_valid_i)                status_o = XL_NO_ENTRY;
    else if (offset_i > ent_limit_i) status_o = XL_LIMIT;
    else if (wrap)                   status_o = XL_WRAP;
    else                             status_o = XL_OK;
  end
endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  xl_status_e      status_i,
  input  logic [PA_W-1:0] sum_i,
  output logic            rsp_valid_o,
  output logic [PA_W-1:0] paddr_o,
  output logic            fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      paddr_o     <= '0;
      fault_o     <= 1'b0;
    end else if (req_i) begin
      rsp_valid_o <= 1'b1;
      fault_o     <= (status_i != XL_OK);
      paddr_o     <= (status_i == XL_OK) ? sum_i : '0;
    end else begin
      rsp_valid_o <= 1'b0;
      paddr_o     <= '0;
      fault_o     <= 1'b0;
    end
  end

  p_fault_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (paddr_o == '0) && rsp_valid_o);

  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (paddr_o == '0) && !fault_o);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W  = VA_W_DEF,
  parameter int unsigned PA_W  = PA_W_DEF,
  parameter int unsigned SEG_W = SEG_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [SEG_W-1:0]        wr_idx_i,
  input  logic                    wr_valid_i,
  input  logic [PA_W-1:0]         wr_base_i,
  input  logic [VA_W-SEG_W-1:0]   wr_limit_i,
  input  logic                    req_i,
  input  logic [VA_W-1:0]         vaddr_i,
  output logic                    rsp_valid_o,
  output logic [PA_W-1:0]         paddr_o,
  output logic                    fault_o
);
  localparam int unsigned OFF_W = VA_W - SEG_W;
  localparam int unsigned CMP_W = ((PA_W > OFF_W) ? PA_W : OFF_W) + 2;

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic             ent_valid;
  logic [PA_W-1:0]  ent_base;
  logic [OFF_W-1:0] ent_limit;
  xl_status_e       status;
  logic [PA_W-1:0]  sum;

  assign seg = vaddr_i[VA_W-1:OFF_W];
  assign off = vaddr_i[OFF_W-1:0];

  seg_desc_file #(.IDX_W(SEG_W), .BASE_W(PA_W), .LIM_W(OFF_W)) u_desc (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_base_i,
    .wr_limit_i, .rd_idx_i(seg), .rd_valid_o(ent_valid),
    .rd_base_o(ent_base), .rd_limit_o(ent_limit)
  );

  seg_check #(.BASE_W(PA_W), .LIM_W(OFF_W)) u_check (
    .ent_valid_i(ent_valid), .ent_base_i(ent_base), .ent_limit_i(ent_limit),
    .offset_i(off), .status_o(status), .sum_o(sum)
  );

  seg_resp_reg #(.PA_W(PA_W)) u_resp (
    .clk_i, .rst_ni, .req_i, .status_i(status), .sum_i(sum),
    .rsp_valid_o, .paddr_o, .fault_o
  );

  p_rsp_follows_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  p_no_req_no_rsp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  p_empty_faults_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ent_valid |=> fault_o);
  p_limit_faults_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ent_valid && (off > ent_limit) |=> fault_o);
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (CMP_W'(ent_base) + CMP_W'(off) > CMP_W'({PA_W{1'b1}})) |=> fault_o);
  p_sum_ok_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ent_valid && (off <= ent_limit) &&
    (CMP_W'(ent_base) + CMP_W'(off) <= CMP_W'({PA_W{1'b1}}))
    |=> !fault_o && (paddr_o == $past(PA_W'(ent_base + PA_W'(off)))));
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [29:0] wr_base_i = '0;
  logic [29:0] wr_limit_i = '0;
  logic        req_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic        rsp_valid_o;
  logic [29:0] paddr_o;
  logic        fault_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  seg_xlate u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_base_i,
    .wr_limit_i, .req_i, .vaddr_i, .rsp_valid_o, .paddr_o, .fault_o
  );

  // {vaddr, fault, paddr}
  localparam logic [62:0] VECS [0:8] = '{
    {32'h8000_0200, 1'b0, 30'h0000_2200},  // R3 example
    {32'h0000_0000, 1'b0, 30'h0000_4000},  // R2 seg 0
    {32'h0000_06FF, 1'b0, 30'h0000_46FF},  // R4 at limit
    {32'h0000_0700, 1'b1, 30'h0000_0000},  // R4 past limit
    {32'h4000_0123, 1'b0, 30'h0000_0123},  // R2 seg 1
    {32'h8000_1000, 1'b1, 30'h0000_0000},  // R4 seg 2 past limit
    {32'hC000_0FFF, 1'b0, 30'h3FFF_FFFF},  // R6 just fits
    {32'hC000_1000, 1'b1, 30'h0000_0000},  // R6 wraps
    {32'hFFFF_FFFF, 1'b1, 30'h0000_0000}   // R6 max offset
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr_desc(input logic [1:0] idx, input logic v,
                         input logic [29:0] b, input logic [29:0] l);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_valid_i = v; wr_base_i = b; wr_limit_i = l;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // issue one request; returns at negedge where its response is visible
  task automatic issue(input logic [31:0] va);
    @(negedge clk_i);
    req_i = 1'b1; vaddr_i = va;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 rsp_valid", 32'(rsp_valid_o), 32'h0);
    check("R1 fault", 32'(fault_o), 32'h0);
    check("R1 paddr", 32'(paddr_o), 32'h0);
    rst_ni = 1'b1;
    issue(32'h4000_0010);
    check("R1 empty after reset valid", 32'(rsp_valid_o), 32'h1);
    check("R1 empty after reset fault", 32'(fault_o), 32'h1);

    wr_desc(2'd0, 1'b1, 30'h0000_4000, 30'h0000_06FF);
    wr_desc(2'd1, 1'b1, 30'h0000_0000, 30'h0000_04FF);
    wr_desc(2'd2, 1'b1, 30'h0000_2000, 30'h0000_0FFF);
    wr_desc(2'd3, 1'b1, 30'h3FFF_F000, 30'h3FFF_FFFF);

    for (int i = 0; i < 9; i++) begin
      issue(VECS[i][62:31]);
      check($sformatf("R3/R4/R6 vec%0d rsp_valid", i), 32'(rsp_valid_o), 32'h1);
      check($sformatf("R3/R4/R6 vec%0d fault", i), 32'(fault_o), 32'(VECS[i][30]));
      check($sformatf("R3/R4/R6 vec%0d paddr", i), 32'(paddr_o), 32'(VECS[i][29:0]));
    end

    // R7: idle cycle after a response clears the outputs
    @(negedge clk_i);
    check("R7 idle rsp_valid", 32'(rsp_valid_o), 32'h0);
    check("R7 idle paddr", 32'(paddr_o), 32'h0);

    // R8: write and request on the same edge, then back-to-back request
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 2'd1; wr_valid_i = 1'b1;
    wr_base_i = 30'h0000_8000; wr_limit_i = 30'h0000_FFFF;
    req_i = 1'b1; vaddr_i = 32'h4000_0010;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R8 same-edge uses old base", 32'(paddr_o), 32'h0000_0010);
    check("R7 first of back-to-back valid", 32'(rsp_valid_o), 32'h1);
    vaddr_i = 32'h4000_0010;
    @(negedge clk_i);
    req_i = 1'b0;
    check("R8 next cycle uses new base", 32'(paddr_o), 32'h0000_8010);
    check("R7 second of back-to-back valid", 32'(rsp_valid_o), 32'h1);

    // R9 / R5: empty a descriptor
    wr_desc(2'd2, 1'b0, 30'h0000_2000, 30'h0000_0FFF);
    issue(32'h8000_0200);
    check("R9 emptied entry fault", 32'(fault_o), 32'h1);
    check("R5 emptied entry paddr", 32'(paddr_o), 32'h0);
    issue(32'h0000_0100);
    check("R2 other entry unaffected", 32'(paddr_o), 32'h0000_4100);

    finish_run();
  end
endmodule